// File: doc/BRIEF.md
# Burst Bus Master Termination Controller

This block is the master side of an external bus with active-low control lines. It takes one request at a time from an internal requester (read or write, single word or burst of up to four 32-bit words) and runs it on the bus. Each bus cycle is an address phase (start strobe low for one clock) followed by a data phase that waits for the slave to terminate it. During a burst the master keeps a "more beats follow" line low for every beat that has a successor, so a burst shorter than four beats is ended by releasing that line early.

The slave ends each beat with an acknowledge, may refuse bursting with a burst-refusal line, or may abort with an error acknowledge. A burst refused on its first beat is finished as separate single-word cycles at rising word addresses. An error, or a data phase that runs too long without any termination, aborts the request and drops its remaining beats. Each completed beat, the final completion and any error are reported to the requester as one-clock pulses.

Top module: `bus_burst_master`

## Requirements
- R1: After reset the start strobe, burst flag and beats-follow line are high (inactive), `req_ready` is high, and `done`, `err` and `beat_valid` are low.
- R2: A request accepted while `req_ready` is high produces `bus_ts_n` low for exactly one clock, with `bus_wr` equal to `req_write` and `bus_burst_n` low only for a burst.
- R3: A burst's address phase carries `req_addr` with its low 4 bits cleared (16-byte line); a single cycle carries `req_addr` with its low 2 bits cleared.
- R4: Each clock in the data phase that samples `bus_ta_n` low (with `bus_tea_n` high) completes one beat: `beat_valid` is high in the next clock with `beat_idx` = beat number (0 first) and `beat_rdata` = `bus_din`; during beat i `bus_dout` = `req_wdata[32*i +: 32]`.
- R5: A burst runs `req_len`+1 beats (`req_len` 0..3); `bus_bdip_n` is low during a burst data phase exactly when the current beat is not the last, so a short burst is ended early by releasing it.
- R6: If `bus_bi_n` is low with the first acknowledge of a burst, that beat counts, and each remaining beat i runs as its own single cycle at line base + 4*i with `bus_burst_n` high.
- R7: `bus_bi_n` has no effect on single cycles or on burst beats after the first.
- R8: `bus_tea_n` low in the data phase aborts the request: `err` pulses in the next clock, no beat is reported for that clock even if `bus_ta_n` is also low, no further bus cycle starts, and `req_ready` returns high.
- R9: If the data phase runs TIMEOUT clocks with both terminations high (no slave answering), `err` pulses in the next clock; an acknowledge in the TIMEOUT-th clock still completes normally.
- R10: `done` pulses in the clock after the last beat's acknowledge; `done` and `err` are never high together and exactly one of them ends each request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken while req_ready is high |
| req_ready | output | 1 | Controller idle, can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = burst, 0 = single word |
| req_len | input | 2 | Burst beats minus one |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 128 | Write words, beat i in bits 32*i+31..32*i |
| beat_valid | output | 1 | One beat completed |
| beat_idx | output | 2 | Number of the completed beat |
| beat_rdata | output | 32 | Read word of the completed beat |
| done | output | 1 | Request finished normally |
| err | output | 1 | Request aborted (error or timeout) |
| bus_addr | output | 32 | Bus address |
| bus_ts_n | output | 1 | Transfer start, active low |
| bus_wr | output | 1 | 1 = write cycle |
| bus_burst_n | output | 1 | Burst cycle flag, active low, valid with start |
| bus_bdip_n | output | 1 | More beats follow, active low |
| bus_dout | output | 32 | Write data |
| bus_din | input | 32 | Read data |
| bus_ta_n | input | 1 | Transfer acknowledge, active low |
| bus_bi_n | input | 1 | Burst refused, active low |
| bus_tea_n | input | 1 | Error acknowledge, active low |

## Verification
The bench builds the block with 32-bit words, four-beat lines and TIMEOUT lowered to 16, which makes the timeout reachable in a few clocks and lets the bench aim an acknowledge at the very last allowed clock. With that configuration it sweeps every burst length, direction, wait-state count of 0 to 2 and burst refusal on or off, then places an error on each beat position with and without a simultaneous acknowledge, and a refusal on a later beat and on single cycles.

// File: rtl/bbm_pkg.sv
package bbm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } bbm_state_e;
endpackage

// File: rtl/bbm_addr_gen.sv
module bbm_addr_gen #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int BEATS = 4,
    localparam int BW   = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic [AW-1:0] req_addr,
    input  logic          req_burst,
    output logic [AW-1:0] req_base,
    input  logic [AW-1:0] cyc_base,
    input  logic [BW-1:0] cyc_beat,
    input  logic          cyc_burst,
    output logic [AW-1:0] cyc_addr
);
    localparam int WORD_SH = $clog2(DW / 8);
    localparam int LINE_SH = $clog2(BEATS * DW / 8);
    localparam logic [AW-1:0] WORD_MASK = {AW{1'b1}} << WORD_SH;
    localparam logic [AW-1:0] LINE_MASK = {AW{1'b1}} << LINE_SH;

    always_comb begin
        req_base = req_addr & (req_burst ? LINE_MASK : WORD_MASK);
        if (cyc_burst)
            cyc_addr = cyc_base;
        else
            cyc_addr = cyc_base + (AW'(cyc_beat) << WORD_SH);
    end
endmodule

// File: rtl/bbm_timer.sv
module bbm_timer #(
    parameter int TIMEOUT = 256,
    localparam int CW     = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = run && (cnt_q == CW'(TIMEOUT - 1));
        if (!run || expire)
            cnt_d = '0;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_count_in_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));
endmodule

// File: rtl/bus_burst_master.sv
module bus_burst_master
    import bbm_pkg::*;
#(
    parameter int AW      = 32,
    parameter int DW      = 32,
    parameter int BEATS   = 4,
    parameter int TIMEOUT = 256,
    localparam int BW     = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic                req_burst,
    input  logic [BW-1:0]       req_len,
    input  logic [AW-1:0]       req_addr,
    input  logic [BEATS*DW-1:0] req_wdata,
    output logic                beat_valid,
    output logic [BW-1:0]       beat_idx,
    output logic [DW-1:0]       beat_rdata,
    output logic                done,
    output logic                err,
    output logic [AW-1:0]       bus_addr,
    output logic                bus_ts_n,
    output logic                bus_wr,
    output logic                bus_burst_n,
    output logic                bus_bdip_n,
    output logic [DW-1:0]       bus_dout,
    input  logic [DW-1:0]       bus_din,
    input  logic                bus_ta_n,
    input  logic                bus_bi_n,
    input  logic                bus_tea_n
);
    localparam int LINE_SH = $clog2(BEATS * DW / 8);

    typedef struct packed {
        bbm_state_e          st;
        logic                burst;
        logic                wr;
        logic [BW-1:0]       last;
        logic [BW-1:0]       beat;
        logic [AW-1:0]       base;
        logic [BEATS*DW-1:0] line;
        logic                bv;
        logic [BW-1:0]       bidx;
        logic [DW-1:0]       brd;
        logic                done;
        logic                err;
    } regs_t;

    regs_t s_d, s_q;
    logic [AW-1:0] req_base;
    logic          tmr_run, tmr_expire;

    bbm_addr_gen #(.AW(AW), .DW(DW), .BEATS(BEATS)) u_addr (
        .req_addr (req_addr),
        .req_burst(req_burst),
        .req_base (req_base),
        .cyc_base (s_q.base),
        .cyc_beat (s_q.beat),
        .cyc_burst(s_q.burst),
        .cyc_addr (bus_addr)
    );

    assign tmr_run = (s_q.st == ST_DATA) && bus_ta_n && bus_tea_n;

    bbm_timer #(.TIMEOUT(TIMEOUT)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (tmr_run),
        .expire(tmr_expire)
    );

    always_comb begin
        s_d      = s_q;
        s_d.bv   = 1'b0;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.st    = ST_ADDR;
                    s_d.burst = req_burst;
                    s_d.wr    = req_write;
                    s_d.last  = req_burst ? req_len : '0;
                    s_d.beat  = '0;
                    s_d.base  = req_base;
                    s_d.line  = req_wdata;
                end
            end
            ST_ADDR: s_d.st = ST_DATA;
            ST_DATA: begin
                if (!bus_tea_n || tmr_expire) begin
                    s_d.err = 1'b1;
                    s_d.st  = ST_IDLE;
                end else if (!bus_ta_n) begin
                    s_d.bv   = 1'b1;
                    s_d.bidx = s_q.beat;
                    s_d.brd  = bus_din;
                    if (s_q.beat == s_q.last) begin
                        s_d.done = 1'b1;
                        s_d.st   = ST_IDLE;
                    end else begin
                        s_d.beat = s_q.beat + 1'b1;
                        if (!s_q.burst) begin
                            s_d.st = ST_ADDR;
                        end else if (s_q.beat == '0 && !bus_bi_n) begin
                            s_d.burst = 1'b0;
                            s_d.st    = ST_ADDR;
                        end
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.st    <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready   = (s_q.st == ST_IDLE);
    assign bus_ts_n    = !(s_q.st == ST_ADDR);
    assign bus_burst_n = !(s_q.st == ST_ADDR && s_q.burst);
    assign bus_bdip_n  = !(s_q.st == ST_DATA && s_q.burst && s_q.beat != s_q.last);
    assign bus_wr      = s_q.wr;
    assign bus_dout    = s_q.line[s_q.beat*DW +: DW];
    assign beat_valid  = s_q.bv;
    assign beat_idx    = s_q.bidx;
    assign beat_rdata  = s_q.brd;
    assign done        = s_q.done;
    assign err         = s_q.err;

    assert_start_one_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ts_n |=> bus_ts_n);
    assert_line_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_ts_n && !bus_burst_n) |-> (bus_addr[LINE_SH-1:0] == '0));
    assert_beat_reported_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_DATA && !bus_ta_n && bus_tea_n && !tmr_expire) |=> beat_valid);
    assert_bdip_in_data_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != ST_DATA) |-> bus_bdip_n);
    assert_refusal_goes_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_DATA && s_q.burst && s_q.beat == '0 && s_q.last != '0
         && !bus_ta_n && bus_tea_n && !bus_bi_n) |=> (!bus_ts_n && bus_burst_n));
    assert_error_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_DATA && !bus_tea_n) |=> (err && !beat_valid && req_ready));
    assert_timeout_error_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_expire |=> err);
    assert_done_err_apart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));
endmodule

// File: tb/sim_bus_burst_master.sv
module sim_bus_burst_master;
    localparam int CLK_PERIOD = 10;
    localparam int T = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
    logic [1:0] req_len = '0;
    logic [31:0] req_addr = '0;
    logic [127:0] req_wdata = '0;
    logic req_ready, beat_valid, done, err;
    logic [1:0] beat_idx;
    logic [31:0] beat_rdata, bus_addr, bus_dout;
    logic bus_ts_n, bus_wr, bus_burst_n, bus_bdip_n;
    logic [31:0] bus_din = '0;
    logic bus_ta_n = 1'b1, bus_bi_n = 1'b1, bus_tea_n = 1'b1;

    bus_burst_master #(.AW(32), .DW(32), .BEATS(4), .TIMEOUT(T)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_burst(req_burst), .req_len(req_len),
        .req_addr(req_addr), .req_wdata(req_wdata), .beat_valid(beat_valid),
        .beat_idx(beat_idx), .beat_rdata(beat_rdata), .done(done), .err(err),
        .bus_addr(bus_addr), .bus_ts_n(bus_ts_n), .bus_wr(bus_wr),
        .bus_burst_n(bus_burst_n), .bus_bdip_n(bus_bdip_n), .bus_dout(bus_dout),
        .bus_din(bus_din), .bus_ta_n(bus_ta_n), .bus_bi_n(bus_bi_n), .bus_tea_n(bus_tea_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_bad = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rd_f(input logic [31:0] a);
        return (a * 32'h9E37) ^ 32'hC0DE_0000;
    endfunction

    function automatic logic [31:0] wr_f(input int id, input int i);
        return 32'hD000_0000 | (32'(id) << 8) | 32'(i);
    endfunction

    // slave configuration
    int cfg_wait = 0, cfg_bi_beat = -1, cfg_tea_beat = -1;
    bit cfg_tea_ta = 0, cfg_noresp = 0;

    // observation logs
    int cyc = 0;
    int n_ts, n_bv, n_ack, n_done, n_err, done_cyc, err_cyc, ts_cyc0, ts_last;
    logic [31:0] ts_addr[8];
    bit ts_burst[8], ts_wr[8];
    int bv_idx[8];
    logic [31:0] bv_data[8], wr_log[8];
    int ack_cyc[8];
    logic bdip_log[8];

    bit active = 0, lburst = 0;
    int wait_cnt = 0, lbeat = 0;
    logic [31:0] cur_addr = '0;

    task automatic clear_logs();
        n_ts = 0; n_bv = 0; n_ack = 0; n_done = 0; n_err = 0;
        done_cyc = -1; err_cyc = -1; ts_cyc0 = -1; ts_last = -1;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (beat_valid && n_bv < 8) begin
            bv_idx[n_bv] = int'(beat_idx);
            bv_data[n_bv] = beat_rdata;
        end
        if (beat_valid) n_bv++;
        if (done) begin n_done++; done_cyc = cyc; end
        if (err)  begin n_err++;  err_cyc = cyc; end
        bus_ta_n = 1'b1; bus_tea_n = 1'b1; bus_bi_n = 1'b1;
        if (!rst_n) begin
            active = 0;
        end else if (!bus_ts_n) begin
            if (n_ts < 8) begin
                ts_addr[n_ts] = bus_addr;
                ts_burst[n_ts] = !bus_burst_n;
                ts_wr[n_ts] = bus_wr;
            end
            if (n_ts == 0) ts_cyc0 = cyc;
            ts_last = cyc;
            n_ts++;
            active = 1; cur_addr = bus_addr; lburst = !bus_burst_n;
            lbeat = 0; wait_cnt = cfg_wait;
        end else if (active && !cfg_noresp) begin
            if (wait_cnt > 0) begin
                wait_cnt--;
            end else if (n_ack == cfg_tea_beat) begin
                bus_tea_n = 1'b0;
                if (cfg_tea_ta) bus_ta_n = 1'b0;
                active = 0;
            end else begin
                bus_ta_n = 1'b0;
                bus_din = rd_f(cur_addr + 32'(4 * lbeat));
                if (n_ack == cfg_bi_beat) bus_bi_n = 1'b0;
                if (n_ack < 8) begin
                    ack_cyc[n_ack] = cyc;
                    bdip_log[n_ack] = bus_bdip_n;
                    wr_log[n_ack] = bus_dout;
                end
                n_ack++; lbeat++;
                if (lburst && !bus_bdip_n) wait_cnt = cfg_wait;
                else active = 0;
            end
        end
    end

    int txn_id = 0;

    task automatic run_txn(input bit burst, input int len, input bit write,
                           input logic [31:0] addr, input int wt, input int bi_beat,
                           input int tea_beat, input bit tea_ta, input bit noresp);
        logic [31:0] base;
        int nb, exp_bv, fall;
        txn_id++;
        cfg_wait = wt; cfg_bi_beat = bi_beat; cfg_tea_beat = tea_beat;
        cfg_tea_ta = tea_ta; cfg_noresp = noresp;
        clear_logs();
        @(negedge clk);
        req_valid = 1'b1; req_burst = burst; req_write = write;
        req_len = 2'(len); req_addr = addr;
        for (int i = 0; i < 4; i++) req_wdata[32*i +: 32] = wr_f(txn_id, i);
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 200 && (n_done + n_err) == 0; k++) @(negedge clk);
        for (int k = 0; k < 4; k++) @(negedge clk);
        #1;
        base = burst ? (addr & 32'hFFFF_FFF0) : (addr & 32'hFFFF_FFFC);
        nb = burst ? len + 1 : 1;
        fall = (burst && bi_beat == 0 && len > 0) ? 1 : 0;
        check(req_ready == 1'b1, "R8/R10 ready after request", req_ready, 1);
        check(n_ts >= 1 && ts_addr[0] == base, "R3 first address", ts_addr[0], base);
        check(ts_burst[0] == burst, "R2 burst flag at start", ts_burst[0], burst);
        check(ts_wr[0] == write, "R2 direction at start", ts_wr[0], write);
        if (noresp) begin
            check(n_err == 1 && n_done == 0, "R9 timeout error", n_err, 1);
            check(err_cyc - ts_cyc0 == T + 1, "R9 timeout latency", err_cyc - ts_cyc0, T + 1);
        end else if (tea_beat >= 0 && tea_beat < nb) begin
            exp_bv = tea_beat;
            check(n_err == 1 && n_done == 0, "R8 abort reports error", n_err, 1);
            check(n_bv == exp_bv, "R8 no beat on error clock", n_bv, exp_bv);
            check(ts_last < err_cyc, "R8 no cycle after abort", ts_last, err_cyc);
        end else begin
            check(n_done == 1 && n_err == 0, "R10 single completion", n_done, 1);
            check(n_bv == nb, "R4 beat count", n_bv, nb);
            check(n_ack == nb, "R5 slave saw burst end", n_ack, nb);
            if (n_ack == nb && nb <= 4)
                check(done_cyc == ack_cyc[nb-1] + 1, "R10 done timing", done_cyc, ack_cyc[nb-1] + 1);
            check(n_ts == (fall ? nb : 1), "R6/R7 address phase count", n_ts, fall ? nb : 1);
            for (int k = 0; k < nb && k < n_bv && k < 8; k++) begin
                check(bv_idx[k] == k, "R4 beat index", bv_idx[k], k);
                if (!write)
                    check(bv_data[k] == rd_f(base + 32'(4*k)), "R4 read data", bv_data[k], rd_f(base + 32'(4*k)));
                else
                    check(wr_log[k] == wr_f(txn_id, k), "R4 write data", wr_log[k], wr_f(txn_id, k));
                check(bdip_log[k] == !(burst && !(fall && k > 0) && k < len),
                      "R5 beats-follow line", bdip_log[k], !(burst && !(fall && k > 0) && k < len));
            end
            if (fall)
                for (int j = 1; j < nb && j < n_ts; j++) begin
                    check(ts_addr[j] == base + 32'(4*j), "R6 single cycle address", ts_addr[j], base + 32'(4*j));
                    check(ts_burst[j] == 1'b0, "R6 single cycle flag", ts_burst[j], 0);
                end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        clear_logs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(bus_ts_n && bus_burst_n && bus_bdip_n, "R1 bus idle", {bus_ts_n, bus_burst_n, bus_bdip_n}, 3'b111);
        check(req_ready && !done && !err && !beat_valid, "R1 requester idle",
              {req_ready, done, err, beat_valid}, 4'b1000);

        // R2 R3 R4 R5 R6 sweep
        for (int w = 0; w < 2; w++)
            for (int wt = 0; wt < 3; wt++) begin
                run_txn(0, 0, w[0], 32'h0000_1236 + 32'(wt*64), wt, -1, -1, 0, 0);
                for (int len = 0; len < 4; len++)
                    for (int bi = 0; bi < 2; bi++)
                        run_txn(1, len, w[0], 32'h0001_0A5C + 32'(len*256), wt, bi ? 0 : -1, -1, 0, 0);
            end

        // R7: refusal on later beat and on single cycles is ignored
        run_txn(1, 3, 0, 32'h0000_4000, 0, 2, -1, 0, 0);
        run_txn(1, 3, 1, 32'h0000_4010, 1, 1, -1, 0, 0);
        run_txn(0, 0, 0, 32'h0000_4024, 0, 0, -1, 0, 0);

        // R8: error on every beat, with and without acknowledge
        for (int b = 0; b < 4; b++)
            for (int both = 0; both < 2; both++)
                run_txn(1, 3, 0, 32'h0000_8000, 1, -1, b, both[0], 0);
        run_txn(1, 3, 0, 32'h0000_8040, 0, 0, 2, 1, 0);
        run_txn(0, 0, 1, 32'h0000_8080, 0, -1, 0, 1, 0);

        // R9: timeout boundary
        run_txn(0, 0, 0, 32'h0000_9000, T - 1, -1, -1, 0, 0);
        run_txn(1, 1, 0, 32'h0000_9100, T - 1, -1, -1, 0, 0);
        run_txn(0, 0, 0, 32'h0000_9200, 0, -1, -1, 0, 1);
        run_txn(1, 3, 1, 32'h0000_9300, 0, -1, -1, 0, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule